// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides a CAN bit into time quanta and marks the two instants a CAN controller needs in each bit: the sample point, where the receive line is read, and the transmit point, where the next bit is driven. It runs from the system clock. Three programmed fields set the timing: a prescaler that fixes the quantum length, the length of the phase before the sample point, and the length of the phase after it. The bit is sequenced as a one-quantum synchronization segment, then the first timing segment, then the second.

Each field is encoded as value plus one. Lengths below the legal minimum are raised to that minimum. The fields are copied into shadow registers only when a new bit starts, so software may write them at any time without corrupting a bit that is already running. While the bus is idle, a recessive-to-dominant edge on the receive line restarts the bit at its synchronization segment. This aligns the node to the start of a frame.

Top module: `can_bit_timer`

## Requirements
- R1: During and right after reset, `seg_state` reads 0 (sync), `tx_pt` is high in the first clock after reset and the quantum count starts from zero.
- R2: `tq_tick` is high for one clock at the end of each time quantum, and a quantum lasts `cfg_brp`+1 clocks.
- R3: The sync segment (`seg_state`=0) lasts exactly one time quantum.
- R4: The first timing segment (`seg_state`=1) lasts max(`cfg_tseg1`+1, 4) quanta.
- R5: The second timing segment (`seg_state`=2) lasts max(`cfg_tseg2`+1, 3) quanta.
- R6: `sample_pt` is high for exactly one clock per bit, in the last clock of the first timing segment.
- R7: `tx_pt` is high for exactly one clock per bit, in the first clock of the sync segment.
- R8: Field values are taken only at reset, at the clock edge that ends a bit, and on hard synchronization. A change to the inputs in the middle of a bit has no effect on that bit.
- R9: When `bus_idle` is high and `rx_line` goes from 1 to 0, the sync segment starts in the next clock and the current field values are taken. The same edge has no effect while `bus_idle` is low.
- R10: `seg_state` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_brp | input | 6 | Prescaler field; quantum = value+1 clocks |
| cfg_tseg1 | input | 4 | Segment-before-sample field; length = value+1 quanta, at least 4 |
| cfg_tseg2 | input | 3 | Segment-after-sample field; length = value+1 quanta, at least 3 |
| bus_idle | input | 1 | High while no frame is in progress |
| rx_line | input | 1 | Receive line, 1 = recessive |
| tq_tick | output | 1 | End of a time quantum |
| sample_pt | output | 1 | Sample strobe |
| tx_pt | output | 1 | Transmit strobe |
| seg_state | output | 2 | 0 sync, 1 first segment, 2 second segment |

## Verification
The assertions assume that `rx_line` is already synchronous to `clk`. They also assume that `bus_idle` comes from logic in the same clock domain, so the edge detector sees clean single-clock transitions. The bench changes every input just after a rising edge and holds it for at least one clock. It writes the fields at random points inside a bit, and it produces falling edges both while idle and while busy. This covers the shadow-load and hard-synchronization paths without ever driving a value that could be metastable.

// File: rtl/can_bt_pkg.sv
// Shared types for the CAN bit timing generator.
// Assumes nothing beyond standard SystemVerilog enum support.
package can_bt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_t;
endpackage

// File: rtl/can_bt_cfg.sv
// Shadow copy of the timing fields with minimum-length clamping.
// Assumes load is a single-clock strobe from the sequencer.
// Output lengths are in quanta; the prescaler value stays in raw form.
module can_bt_cfg #(
    parameter int BRP_W  = 6,
    parameter int TS1_W  = 4,
    parameter int TS2_W  = 3,
    parameter int MIN1   = 4,
    parameter int MIN2   = 3,
    localparam int LEN1_W = TS1_W + 1,
    localparam int LEN2_W = TS2_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BRP_W-1:0]  raw_brp,
    input  logic [TS1_W-1:0]  raw_ts1,
    input  logic [TS2_W-1:0]  raw_ts2,
    output logic [BRP_W-1:0]  brp_s,
    output logic [LEN1_W-1:0] len1_s,
    output logic [LEN2_W-1:0] len2_s
);
    logic [LEN1_W-1:0] len1_n;
    logic [LEN2_W-1:0] len2_n;

    // Clamp the value-plus-one lengths up to their minimums.
    always_comb begin
        len1_n = LEN1_W'(raw_ts1) + LEN1_W'(1);
        if (len1_n < LEN1_W'(MIN1)) len1_n = LEN1_W'(MIN1);
        len2_n = LEN2_W'(raw_ts2) + LEN2_W'(1);
        if (len2_n < LEN2_W'(MIN2)) len2_n = LEN2_W'(MIN2);
    end

    // Capture the fields at reset and on each load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            brp_s  <= raw_brp;
            len1_s <= len1_n;
            len2_s <= len2_n;
        end
    end

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(brp_s) && $stable(len1_s) && $stable(len2_s)));
    assert_len_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (len1_s >= LEN1_W'(MIN1)) && (len2_s >= LEN2_W'(MIN2)));
endmodule

// File: rtl/can_bt_presc.sv
// Time-quantum prescaler: counts brp+1 clocks per quantum.
// Assumes brp only changes on the same edge as a restart or a wrap.
module can_bt_presc #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [BRP_W-1:0] brp,
    output logic             tick,
    output logic             first
);
    logic [BRP_W-1:0] pcnt;

    // Flag the last and first clock of each quantum.
    always_comb begin
        tick  = (pcnt == brp);
        first = (pcnt == '0);
    end

    // Count clocks within a quantum, restart on hard sync.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) pcnt <= '0;
        else                           pcnt <= pcnt + BRP_W'(1);
    end

    assert_pcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= brp);
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> first);
endmodule

// File: rtl/can_bt_seq.sv
// Segment sequencer: walks sync, first and second segment in quanta,
// produces the strobes and detects hard-sync edges while idle.
// Assumes rx_line and bus_idle are synchronous to clk.
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int LEN1_W = 5,
    parameter int LEN2_W = 4,
    localparam int Q_W = (LEN1_W > LEN2_W) ? LEN1_W : LEN2_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              first,
    input  logic [LEN1_W-1:0] len1,
    input  logic [LEN2_W-1:0] len2,
    input  logic              bus_idle,
    input  logic              rx_line,
    output logic              hsync,
    output logic              load,
    output logic              sample_pt,
    output logic              tx_pt,
    output seg_t              seg
);
    logic [Q_W-1:0] qcnt;
    logic           rx_prev;
    logic           last_tq;
    logic           end_bit;

    // Decode segment ends, strobes and the hard-sync edge.
    always_comb begin
        hsync = bus_idle && rx_prev && !rx_line;
        unique case (seg)
            SEG_SYNC: last_tq = 1'b1;
            SEG_PH1:  last_tq = (qcnt == Q_W'(len1) - Q_W'(1));
            SEG_PH2:  last_tq = (qcnt == Q_W'(len2) - Q_W'(1));
            default:  last_tq = 1'b1;
        endcase
        end_bit   = tick && last_tq && (seg == SEG_PH2);
        load      = hsync || end_bit;
        sample_pt = tick && last_tq && (seg == SEG_PH1);
        tx_pt     = (seg == SEG_SYNC) && first;
    end

    // Remember the previous receive level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_prev <= 1'b1;
        else        rx_prev <= rx_line;
    end

    // Advance through the segments one quantum at a time.
    always_ff @(posedge clk) begin
        if (!rst_n || hsync) begin
            seg  <= SEG_SYNC;
            qcnt <= '0;
        end else if (tick) begin
            if (last_tq) begin
                qcnt <= '0;
                unique case (seg)
                    SEG_SYNC: seg <= SEG_PH1;
                    SEG_PH1:  seg <= SEG_PH2;
                    default:  seg <= SEG_SYNC;
                endcase
            end else begin
                qcnt <= qcnt + Q_W'(1);
            end
        end
    end

    assert_seg_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seg != 2'd3);
    assert_sample_place_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |-> (seg == SEG_PH1 && tick));
    assert_tx_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pt && !hsync) |=> !tx_pt);
    assert_hsync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (seg == SEG_SYNC));
    assert_sync_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_SYNC && tick && !hsync) |=> (seg == SEG_PH1));
endmodule

// File: rtl/can_bit_timer.sv
// CAN bit timing generator top: shadow fields, quantum prescaler and
// segment sequencer. Assumes all inputs are synchronous to clk.
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter int BRP_W = 6,
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int MIN1  = 4,
    parameter int MIN2  = 3,
    localparam int LEN1_W = TS1_W + 1,
    localparam int LEN2_W = TS2_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [TS1_W-1:0] cfg_tseg1,
    input  logic [TS2_W-1:0] cfg_tseg2,
    input  logic             bus_idle,
    input  logic             rx_line,
    output logic             tq_tick,
    output logic             sample_pt,
    output logic             tx_pt,
    output logic [1:0]       seg_state
);
    logic [BRP_W-1:0]  brp_s;
    logic [LEN1_W-1:0] len1_s;
    logic [LEN2_W-1:0] len2_s;
    logic              load;
    logic              hsync;
    logic              q_first;
    seg_t              seg;

    can_bt_cfg #(.BRP_W(BRP_W), .TS1_W(TS1_W), .TS2_W(TS2_W),
                 .MIN1(MIN1), .MIN2(MIN2)) i_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .raw_brp(cfg_brp), .raw_ts1(cfg_tseg1), .raw_ts2(cfg_tseg2),
        .brp_s(brp_s), .len1_s(len1_s), .len2_s(len2_s));

    can_bt_presc #(.BRP_W(BRP_W)) i_presc (
        .clk(clk), .rst_n(rst_n), .restart(hsync), .brp(brp_s),
        .tick(tq_tick), .first(q_first));

    can_bt_seq #(.LEN1_W(LEN1_W), .LEN2_W(LEN2_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .tick(tq_tick), .first(q_first),
        .len1(len1_s), .len2(len2_s), .bus_idle(bus_idle), .rx_line(rx_line),
        .hsync(hsync), .load(load), .sample_pt(sample_pt), .tx_pt(tx_pt),
        .seg(seg));

    // Expose the segment code on a plain vector port.
    always_comb seg_state = seg;

    assert_one_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |=> !sample_pt);
endmodule

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_brp = 6'd0;
    logic [3:0] cfg_tseg1 = 4'd1;
    logic [2:0] cfg_tseg2 = 3'd0;
    logic       bus_idle = 1'b0;
    logic       rx_line = 1'b1;
    logic       tq_tick, sample_pt, tx_pt;
    logic [1:0] seg_state;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural model: position of the current clock within the bit
    int m_pos = 0, m_brp = 0, m_l1 = 4, m_l2 = 3, m_rxp = 1;
    bit m_ok = 0;

    can_bit_timer i_can_bit_timer (
        .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_tseg1(cfg_tseg1),
        .cfg_tseg2(cfg_tseg2), .bus_idle(bus_idle), .rx_line(rx_line),
        .tq_tick(tq_tick), .sample_pt(sample_pt), .tx_pt(tx_pt),
        .seg_state(seg_state));

    always #4 clk = ~clk;

    function automatic int clampi(int v, int m);
        return (v < m) ? m : v;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic m_load();
        m_brp = cfg_brp;
        m_l1 = clampi(int'(cfg_tseg1) + 1, 4);
        m_l2 = clampi(int'(cfg_tseg2) + 1, 3);
    endtask

    // compare against the model, then advance it for the coming edge
    always @(negedge clk) begin
        int q, tqi, eseg, blen;
        cycles++;
        if (rst_n && m_ok && !done) begin
            q = m_brp + 1;
            tqi = m_pos / q;
            eseg = (tqi == 0) ? 0 : (tqi < 1 + m_l1) ? 1 : 2;
            check("R2 R8 R9 tq_tick", tq_tick, ((m_pos + 1) % q) == 0);
            check("R6 sample_pt", sample_pt, m_pos == (1 + m_l1) * q - 1);
            check("R7 R1 tx_pt", tx_pt, m_pos == 0);
            check("R3 R4 R5 R10 seg_state", seg_state, eseg);
        end
        if (!rst_n) begin
            m_pos = 0; m_rxp = 1; m_load(); m_ok = 1;
        end else begin
            blen = (1 + m_l1 + m_l2) * (m_brp + 1);
            if ((bus_idle && m_rxp == 1 && !rx_line) || m_pos == blen - 1) begin
                m_pos = 0; m_load();
            end else begin
                m_pos++;
            end
            m_rxp = rx_line;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic falling_edge(bit idle);
        bus_idle = idle; rx_line = 1'b0; step(1);
        rx_line = 1'b1; step(1);
        bus_idle = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state seen at the ports
        check("R1 seg after reset", seg_state, 0);
        check("R1 tx after reset", tx_pt, 1);
        #1;
        // R4 R5 clamped minimum lengths with one-clock quanta
        step(60);
        // R8 change fields mid-bit
        step(5); cfg_brp = 6'd2; cfg_tseg1 = 4'd5; cfg_tseg2 = 3'd4;
        step(200);
        cfg_brp = 6'd1; cfg_tseg1 = 4'd15; cfg_tseg2 = 3'd7;
        step(7); cfg_brp = 6'd3;
        step(300);
        // R9 hard sync while idle, at several points in the bit
        for (int k = 0; k < 6; k++) begin
            step(13 + 7 * k);
            falling_edge(1'b1);
        end
        // R9 edges while busy are ignored
        for (int k = 0; k < 4; k++) begin
            step(9 + 5 * k);
            falling_edge(1'b0);
        end
        // R9 held low while idle: only the first edge counts
        step(11); bus_idle = 1'b1; rx_line = 1'b0; step(40);
        rx_line = 1'b1; bus_idle = 1'b0;
        // R2 long prescaler and widest segments
        cfg_brp = 6'd63; cfg_tseg1 = 4'd15; cfg_tseg2 = 3'd7;
        step(3500);
        cfg_brp = 6'd0; cfg_tseg1 = 4'd3; cfg_tseg2 = 3'd2;
        step(3000);
        // R1 reset in the middle of a bit
        rst_n = 1'b0; step(2); rst_n = 1'b1;
        step(100);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule